// File: doc/BRIEF.md
# Predicated Pairwise Widening Add-Accumulate

This block is one slice of a vector datapath. It receives a source vector, an accumulator vector and a byte-granular predicate. The vector is cut into destination elements of 16, 32 or 64 bits. For every active element, the block splits the matching source element into its two half-width parts. It widens both parts and adds them to the accumulator element. The sum wraps at the element width. Inactive elements pass the accumulator value through unchanged, because the accumulator and the result share one destination register.

Operands arrive through a valid/ready handshake. The result appears in a register one cycle after acceptance and stays there until the consumer takes it. An operand size code that has no allocation raises an illegal flag and returns the accumulator untouched.

Top module: `pairwise_acc_long`

## Requirements
- R1: Each active destination element of width E is computed as acc + ext(low E/2 bits of the source element) + ext(high E/2 bits of the source element), taken modulo 2^E with no saturation.
- R2: When `is_unsigned` is 0, both halves are sign-extended before the add. When it is 1, both halves are zero-extended.
- R3: `size_code` 1, 2 and 3 select destination elements of 16, 32 and 64 bits. Element i occupies bits [i*E +: E], and its low half is bits [i*E +: E/2].
- R4: `size_code` 0 is illegal. The accepted request yields `illegal`=1 and a result equal to the accumulator input. Any other code yields `illegal`=0.
- R5: The predicate has one bit per byte of the vector. Element i is active when `pred[i*E/8]` is 1. An inactive element outputs its accumulator value.
- R6: A request is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` equals !`out_valid` or `out_ready`. The next cycle shows `out_valid`=1 together with that request's result.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `result` and `illegal` hold their values.
- R8: After reset, `out_valid`, `illegal` and `result` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| size_code | input | 2 | Destination element size code |
| is_unsigned | input | 1 | 1 = zero-extend halves, 0 = sign-extend |
| src_vec | input | VLEN | Source vector of packed half-width pairs |
| acc_vec | input | VLEN | Accumulator (destination) vector |
| pred | input | VLEN/8 | Governing predicate, one bit per byte |
| out_valid | output | 1 | Result register holds an untaken result |
| out_ready | input | 1 | Consumer takes the result |
| result | output | VLEN | Registered destination vector |
| illegal | output | 1 | Registered illegal-encoding flag |

## Verification
The bench builds the block with VLEN = 256. At that width there are 16, 8 and 4 lanes per size, so it covers the highest lane of every size and the predicate bits that lie inside an element and must be ignored. The reference model works on 64-bit integers, which allows it to check the full 64-bit wraparound.

// File: rtl/pairwise_acc_long.sv
module pairwise_acc_long #(
  parameter int VLEN = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        size_code,
  input  logic              is_unsigned,
  input  logic [VLEN-1:0]   src_vec,
  input  logic [VLEN-1:0]   acc_vec,
  input  logic [VLEN/8-1:0] pred,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [VLEN-1:0]   result,
  output logic              illegal
);
  localparam int NSIZES = 3;

  logic [NSIZES-1:0][VLEN-1:0] by_size;
  logic [VLEN-1:0] next_res;
  logic fire;
  logic unused_pred_parity;

  assign unused_pred_parity = ^pred;
  assign in_ready = ~out_valid | out_ready;
  assign fire = in_valid & in_ready;

  for (genvar g = 0; g < NSIZES; g++) begin : g_size
    localparam int E = 16 << g;
    localparam int W = E / 2;
    localparam int N = VLEN / E;
    for (genvar i = 0; i < N; i++) begin : g_lane
      logic [W-1:0] lo, hi;
      logic [E-1:0] lo_x, hi_x, acc, sum;
      assign lo   = src_vec[i*E +: W];
      assign hi   = src_vec[i*E+W +: W];
      assign lo_x = {{W{lo[W-1] & ~is_unsigned}}, lo};
      assign hi_x = {{W{hi[W-1] & ~is_unsigned}}, hi};
      assign acc  = acc_vec[i*E +: E];
      assign sum  = acc + lo_x + hi_x;
      assign by_size[g][i*E +: E] = pred[i*E/8] ? sum : acc;
    end
  end

  always_comb begin
    case (size_code)
      2'd1:    next_res = by_size[0];
      2'd2:    next_res = by_size[1];
      2'd3:    next_res = by_size[2];
      default: next_res = acc_vec;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      illegal   <= 1'b0;
      result    <= '0;
    end else if (fire) begin
      out_valid <= 1'b1;
      illegal   <= (size_code == 2'd0);
      result    <= next_res;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

module pairwise_acc_long_chk #(
  parameter int VLEN = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [1:0]        size_code,
  input logic              is_unsigned,
  input logic [VLEN-1:0]   src_vec,
  input logic [VLEN-1:0]   acc_vec,
  input logic [VLEN/8-1:0] pred,
  input logic              out_valid,
  input logic              out_ready,
  input logic [VLEN-1:0]   result,
  input logic              illegal
);
  logic unused_chk;
  assign unused_chk = is_unsigned ^ (^src_vec);

  always_comb begin
    if (!rst_n) begin
      assert_reset_clear_R8: assert (!out_valid && !illegal && result == '0);
    end
  end

  assert_accept_shows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_ready_rule_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (!out_valid || out_ready));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(result) && $stable(illegal)));

  assert_illegal_keeps_acc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && size_code == 2'd0) |=> (illegal && result == $past(acc_vec)));

  assert_legal_no_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && size_code != 2'd0) |=> !illegal);

  assert_inactive_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && size_code == 2'd3 && !pred[0]) |=> result[63:0] == $past(acc_vec[63:0]));
endmodule

bind pairwise_acc_long pairwise_acc_long_chk #(.VLEN(VLEN)) u_chk (.*);

// File: tb/pairwise_acc_long_bench.sv
module pairwise_acc_long_bench;
  localparam int VLEN = 256;
  localparam int PB = VLEN / 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic in_valid = 1'b0, is_unsigned = 1'b0, out_ready = 1'b1;
  logic [1:0] size_code = 2'd1;
  logic [VLEN-1:0] src_vec = '0, acc_vec = '0;
  logic [PB-1:0] pred = '0;
  logic in_ready, out_valid, illegal;
  logic [VLEN-1:0] result;

  pairwise_acc_long #(.VLEN(VLEN)) u_pairwise_acc_long (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .size_code(size_code), .is_unsigned(is_unsigned), .src_vec(src_vec),
    .acc_vec(acc_vec), .pred(pred), .out_valid(out_valid), .out_ready(out_ready),
    .result(result), .illegal(illegal));

  int total = 0, bad = 0;
  string tag = "R8";
  bit m_valid = 0, m_ill = 0;
  logic [VLEN-1:0] m_res = '0;

  function automatic logic [VLEN-1:0] ref_calc(input logic [1:0] sz, input logic uns,
      input logic [VLEN-1:0] s, input logic [VLEN-1:0] a, input logic [PB-1:0] p);
    logic [VLEN-1:0] r;
    int e, w;
    r = a;
    if (sz == 2'd0) return r;
    e = 8 << sz;
    w = e / 2;
    for (int i = 0; i < VLEN / e; i++) begin
      logic [63:0] lo, hi, ac, msk, hm, sum;
      msk = (e == 64) ? '1 : ((64'd1 << e) - 64'd1);
      hm  = (64'd1 << w) - 64'd1;
      lo  = 64'(s >> (i * e)) & hm;
      hi  = 64'(s >> (i * e + w)) & hm;
      if (!uns) begin
        if (lo[w-1]) lo = lo | ~hm;
        if (hi[w-1]) hi = hi | ~hm;
      end
      ac = 64'(a >> (i * e)) & msk;
      if (p[i * e / 8]) begin
        sum = (ac + lo + hi) & msk;
        for (int b = 0; b < e; b++) r[i * e + b] = sum[b];
      end
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 0; m_ill = 0; m_res = '0;
    end else if (in_valid && (!m_valid || out_ready)) begin
      m_valid = 1;
      m_ill = (size_code == 2'd0);
      m_res = ref_calc(size_code, is_unsigned, src_vec, acc_vec, pred);
    end else if (m_valid && out_ready) begin
      m_valid = 0;
    end
  end

  task automatic check_bit(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check_bit("R6 out_valid", out_valid, m_valid);
      check_bit("R6 in_ready", in_ready, !m_valid || out_ready);
      if (m_valid) begin
        check_bit("R4 illegal", illegal, m_ill);
        total++;
        if (result !== m_res) begin
          bad++;
          $display("FAIL %s result act=%h exp=%h", tag, result, m_res);
        end
      end
    end
  end

  function automatic logic [VLEN-1:0] rv();
    logic [VLEN-1:0] v;
    for (int k = 0; k < VLEN / 32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic send(input logic [1:0] sz, input logic uns, input logic [VLEN-1:0] s,
                      input logic [VLEN-1:0] a, input logic [PB-1:0] p);
    @(negedge clk);
    in_valid = 1; size_code = sz; is_unsigned = uns; src_vec = s; acc_vec = a; pred = p;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check_bit("R8 out_valid", out_valid, 1'b0);
    check_bit("R8 illegal", illegal, 1'b0);
    total++;
    if (result !== '0) begin bad++; $display("FAIL R8 result act=%h exp=0", result); end
    rst_n = 1;

    tag = "R3";
    for (int sz = 1; sz < 4; sz++)
      for (int u = 0; u < 2; u++) send(2'(sz), u[0], rv(), rv(), '1);
    idle(1);

    tag = "R2";
    for (int sz = 1; sz < 4; sz++)
      for (int u = 0; u < 2; u++) begin
        send(2'(sz), u[0], '1, '0, '1);
        send(2'(sz), u[0], {PB{8'h80}}, rv(), '1);
        send(2'(sz), u[0], {(VLEN/16){16'h807F}}, '0, '1);
      end
    idle(1);

    tag = "R1";
    for (int sz = 1; sz < 4; sz++) begin
      send(2'(sz), 1'b1, '1, '1, '1);
      send(2'(sz), 1'b0, {PB{8'h80}}, {PB{8'h80}}, '1);
    end
    idle(1);

    tag = "R5";
    for (int sz = 1; sz < 4; sz++) begin
      send(2'(sz), 1'b0, rv(), rv(), '0);
      send(2'(sz), 1'b1, rv(), rv(), {(PB/2){2'b01}});
      send(2'(sz), 1'b0, rv(), rv(), {(PB/2){2'b10}});
      send(2'(sz), 1'b1, rv(), rv(), PB'(rv()));
    end
    idle(1);

    tag = "R4";
    send(2'd0, 1'b0, rv(), rv(), '1);
    send(2'd0, 1'b1, rv(), rv(), '0);
    send(2'd2, 1'b0, rv(), rv(), '1);
    idle(1);

    tag = "R7";
    @(negedge clk); out_ready = 0;
    send(2'd3, 1'b0, rv(), rv(), '1);
    @(negedge clk);
    in_valid = 1; size_code = 2'd1; src_vec = rv(); acc_vec = rv(); pred = '1;
    repeat (4) @(negedge clk);
    out_ready = 1;
    idle(2);

    tag = "R6";
    for (int n = 0; n < 300; n++) begin
      @(negedge clk);
      out_ready = ($urandom % 3) != 0;
      if ($urandom % 4 == 0) begin
        in_valid = 0;
      end else begin
        in_valid = 1; size_code = 2'($urandom); is_unsigned = 1'($urandom);
        src_vec = rv(); acc_vec = rv(); pred = PB'(rv());
      end
    end
    @(negedge clk); in_valid = 0; out_ready = 1;
    idle(3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule